// File: doc/BRIEF.md
# Fast-Charge Termination Detector for Nickel Cells

This block decides when the fast-charge phase of a nickel-cell charger should end. It watches a stream of periodic samples of the average single-cell voltage and of the pack temperature. It fires on one of two events. The first is a voltage fall below the highest voltage seen since fast charge began (negative delta-V). The second is a temperature rise over the last minute that reaches a chemistry-dependent slope limit. A surrounding sequencer acquires the samples, runs the stabilization timer and chooses the next charging phase.

The sequencer pulses `fc_start` at the start of every fast-charge cycle. It then presents samples with `smp_valid`. The first sample accepted after a start records the initial cell voltage. A pack whose initial voltage is above the charged level (1325 mV by default) counts as already charged. When the detector fires it raises `term_pulse` for one cycle, together with a cause code and a flag. The flag tells whether a slope event came after the initial window, so that the sequencer can decide on a top-off phase. After firing, the detector waits for the next start.

The controller has four states, and the transitions between them are named here. IDLE goes to PRIME on start. PRIME goes to TRACK on the first accepted sample (capture). TRACK goes to DONE when a criterion hits (fire). Every state goes to PRIME on start (re-arm).

Top module: `tem_terminator`

## Requirements
- R1: After reset `term_pulse`, `term_cause` and `slope_late` are 0. Samples presented before the first `fc_start` are ignored.
- R2: The first accepted sample after `fc_start` only records the initial voltage, the peak and the first window entry. It never fires.
- R3: In TRACK, the voltage criterion hits when `cell_mv + dv_limit <= peak`. The peak is the highest accepted voltage since start. `dv_limit` is 20 mV for NiCd (`chem_nimh`=0) and 10 mV for NiMH (`chem_nimh`=1).
- R4: The voltage criterion is blocked until `hold_win_done`=1. The block is lifted at once if the initial voltage exceeded the charged level or if `from_recharge`=1.
- R5: The slope criterion hits when the temperature (tenths of °C) minus the value WIN_DEPTH accepted samples earlier reaches the slope limit. The limit is 20 for NiCd. For NiMH it is 10, except 15 while `hold_win_done`=0, `from_recharge`=0 and the pack was not charged at start.
- R6: The slope criterion is evaluated only once WIN_DEPTH samples have been accepted since start.
- R7: With `therm_en`=0 the slope criterion never hits. Only the voltage criterion can end the charge.
- R8: A sample presented while `pause`=1 is fully ignored. It does not update the peak, does not enter the window and does not fire.
- R9: A hit raises `term_pulse` for one cycle, in the cycle after the sample. `term_cause` bit 0 marks the voltage criterion and bit 1 the slope criterion, and both bits are set when both hit on the same sample. `slope_late` equals `hold_win_done` when the slope criterion hits. Both `term_cause` and `slope_late` are 0 when there is no pulse.
- R10: After firing, samples are ignored until the next `fc_start`.
- R11: `fc_start` clears the peak, the window and the charged flag. A sample presented in the same cycle as `fc_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_start | input | 1 | Start of a fast-charge cycle (pulse) |
| smp_valid | input | 1 | A new sample is present |
| cell_mv | input | MV_W | Average cell voltage, mV |
| temp_dt | input | T_W | Pack temperature, tenths of °C |
| chem_nimh | input | 1 | 1 = NiMH limits, 0 = NiCd limits |
| therm_en | input | 1 | Thermistor present, slope criterion allowed |
| pause | input | 1 | Inhibit all termination processing |
| from_recharge | input | 1 | Cycle started from automatic recharge |
| hold_win_done | input | 1 | Initial stabilization window has expired |
| term_pulse | output | 1 | One-cycle termination event |
| term_cause | output | 2 | bit0 voltage, bit1 slope |
| slope_late | output | 1 | Slope event came after the initial window |

## Verification
Some properties are checked on every cycle. A pulse never lasts two cycles. A pulse always follows an accepted, unpaused sample. The cause code is non-zero exactly when a pulse is present. A slope cause implies the thermistor was enabled. A voltage cause implies the hold-off had been lifted. Other behaviour only shows in the bench's scenarios. These cover the exact hit boundaries for both chemistries, the switch between the early and late NiMH slope limits, the window-fill rule, the peak staying frozen under pause, and a sample that coincides with a start being discarded.

// File: rtl/tem_pkg.sv
package tem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_TRACK,
        ST_DONE
    } tem_state_e;

    localparam logic [1:0] CAUSE_NONE  = 2'b00;
    localparam logic [1:0] CAUSE_VOLT  = 2'b01;
    localparam logic [1:0] CAUSE_SLOPE = 2'b10;
endpackage

// File: rtl/tem_peak.sv
module tem_peak #(
    parameter int MV_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            upd,
    input  logic [MV_W-1:0] mv,
    output logic [MV_W-1:0] peak
);
    logic [MV_W-1:0] peak_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (clear) begin
            peak_q <= '0;
        end else if (upd && (mv > peak_q)) begin
            peak_q <= mv;
        end
    end

    assign peak = peak_q;
endmodule

// File: rtl/tem_slope.sv
module tem_slope #(
    parameter int T_W   = 10,
    parameter int DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           push,
    input  logic [T_W-1:0] temp_in,
    output logic           full,
    output logic [T_W-1:0] rise
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [T_W-1:0]   hist [DEPTH];
    logic [CNT_W-1:0] fill_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist[i] <= '0;
                end else if (clear) begin
                    hist[i] <= '0;
                end else if (push) begin
                    if (i == 0) begin
                        hist[i] <= temp_in;
                    end else begin
                        hist[i] <= hist[(i == 0) ? 0 : i-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clear) begin
            fill_q <= '0;
        end else if (push && !full) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign full = (fill_q == CNT_W'(DEPTH));
    assign rise = (temp_in > hist[DEPTH-1]) ? (temp_in - hist[DEPTH-1]) : '0;
endmodule

// File: rtl/tem_thresh.sv
module tem_thresh #(
    parameter int MV_W        = 12,
    parameter int T_W         = 10,
    parameter int NICD_DV     = 20,
    parameter int NIMH_DV     = 10,
    parameter int NICD_SLOPE  = 20,
    parameter int NIMH_SLOPE  = 10,
    parameter int NIMH_EARLY  = 15
) (
    input  logic            chem_nimh,
    input  logic            early,
    output logic [MV_W-1:0] dv_thr,
    output logic [T_W-1:0]  slope_thr
);
    always_comb begin
        if (chem_nimh) begin
            dv_thr    = MV_W'(NIMH_DV);
            slope_thr = early ? T_W'(NIMH_EARLY) : T_W'(NIMH_SLOPE);
        end else begin
            dv_thr    = MV_W'(NICD_DV);
            slope_thr = T_W'(NICD_SLOPE);
        end
    end
endmodule

// File: rtl/tem_terminator.sv
module tem_terminator #(
    parameter int MV_W       = 12,
    parameter int T_W        = 10,
    parameter int WIN_DEPTH  = 4,
    parameter int CHARGED_MV = 1325,
    parameter int NICD_DV    = 20,
    parameter int NIMH_DV    = 10,
    parameter int NICD_SLOPE = 20,
    parameter int NIMH_SLOPE = 10,
    parameter int NIMH_EARLY = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fc_start,
    input  logic            smp_valid,
    input  logic [MV_W-1:0] cell_mv,
    input  logic [T_W-1:0]  temp_dt,
    input  logic            chem_nimh,
    input  logic            therm_en,
    input  logic            pause,
    input  logic            from_recharge,
    input  logic            hold_win_done,
    output logic            term_pulse,
    output logic [1:0]      term_cause,
    output logic            slope_late
);
    import tem_pkg::*;

    tem_state_e      state_q, state_d;
    logic            charged_q;
    logic            accept, in_track, released, early;
    logic            v_hit, s_hit, fire;
    logic [MV_W-1:0] peak, dv_thr;
    logic [T_W-1:0]  rise, slope_thr;
    logic            win_full;

    assign accept   = smp_valid && !pause && !fc_start &&
                      ((state_q == ST_PRIME) || (state_q == ST_TRACK));
    assign in_track = (state_q == ST_TRACK);
    assign released = charged_q || from_recharge || hold_win_done;
    assign early    = !released;

    tem_peak #(.MV_W(MV_W)) peak_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fc_start),
        .upd   (accept),
        .mv    (cell_mv),
        .peak  (peak)
    );

    tem_slope #(.T_W(T_W), .DEPTH(WIN_DEPTH)) slope_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (fc_start),
        .push    (accept),
        .temp_in (temp_dt),
        .full    (win_full),
        .rise    (rise)
    );

    tem_thresh #(
        .MV_W(MV_W), .T_W(T_W),
        .NICD_DV(NICD_DV), .NIMH_DV(NIMH_DV),
        .NICD_SLOPE(NICD_SLOPE), .NIMH_SLOPE(NIMH_SLOPE),
        .NIMH_EARLY(NIMH_EARLY)
    ) thresh_i (
        .chem_nimh (chem_nimh),
        .early     (early),
        .dv_thr    (dv_thr),
        .slope_thr (slope_thr)
    );

    // Criteria evaluation on the accepted sample
    assign v_hit = in_track && accept && released &&
                   (({1'b0, cell_mv} + {1'b0, dv_thr}) <= {1'b0, peak});
    assign s_hit = in_track && accept && therm_en && win_full &&
                   (rise >= slope_thr);
    assign fire  = v_hit || s_hit;

    // Next-state logic: capture, fire, re-arm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  begin end
            ST_PRIME: begin
                if (accept) state_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (fire) state_d = ST_DONE;
            end
            ST_DONE:  begin end
        endcase
        if (fc_start) state_d = ST_PRIME;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Initial-voltage qualification
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            charged_q <= 1'b0;
        end else if (fc_start) begin
            charged_q <= 1'b0;
        end else if ((state_q == ST_PRIME) && accept) begin
            charged_q <= (cell_mv > MV_W'(CHARGED_MV));
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_pulse <= 1'b0;
            term_cause <= CAUSE_NONE;
            slope_late <= 1'b0;
        end else begin
            term_pulse <= fire;
            term_cause <= fire ? {s_hit, v_hit} : CAUSE_NONE;
            slope_late <= s_hit && hold_win_done;
        end
    end
endmodule

// File: rtl/tem_terminator_chk.sv
module tem_terminator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fc_start,
    input logic       smp_valid,
    input logic       pause,
    input logic       therm_en,
    input logic       from_recharge,
    input logic       hold_win_done,
    input logic       charged_q,
    input logic       term_pulse,
    input logic [1:0] term_cause,
    input logic       slope_late
);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |=> !term_pulse);

    assert_pulse_after_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |-> ($past(smp_valid) && !$past(pause) && !$past(fc_start)));

    assert_cause_matches_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse == (term_cause != 2'b00));

    assert_late_needs_slope_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slope_late |-> (term_cause[1] && $past(hold_win_done)));

    assert_slope_needs_therm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        term_cause[1] |-> $past(therm_en));

    assert_volt_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        term_cause[0] |-> ($past(hold_win_done) || $past(from_recharge) || $past(charged_q)));
endmodule

bind tem_terminator tem_terminator_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fc_start      (fc_start),
    .smp_valid     (smp_valid),
    .pause         (pause),
    .therm_en      (therm_en),
    .from_recharge (from_recharge),
    .hold_win_done (hold_win_done),
    .charged_q     (charged_q),
    .term_pulse    (term_pulse),
    .term_cause    (term_cause),
    .slope_late    (slope_late)
);

// File: tb/tem_terminator_tb_top.sv
module tem_terminator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] cell_mv = '0;
    logic [9:0]  temp_dt = '0;
    logic        chem_nimh = 1'b0;
    logic        therm_en = 1'b0;
    logic        pause = 1'b0;
    logic        from_recharge = 1'b0;
    logic        hold_win_done = 1'b0;
    logic        term_pulse;
    logic [1:0]  term_cause;
    logic        slope_late;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    tem_terminator dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fc_start      (fc_start),
        .smp_valid     (smp_valid),
        .cell_mv       (cell_mv),
        .temp_dt       (temp_dt),
        .chem_nimh     (chem_nimh),
        .therm_en      (therm_en),
        .pause         (pause),
        .from_recharge (from_recharge),
        .hold_win_done (hold_win_done),
        .term_pulse    (term_pulse),
        .term_cause    (term_cause),
        .slope_late    (slope_late)
    );

    // ctl = {start, pause, chem_nimh, therm_en, from_recharge, hold_win_done}
    // exp = {pulse, cause[1:0], late}; last field is the requirement number
    localparam int NV = 63;
    localparam logic [35:0] VEC [NV] = '{
        // NiCd voltage drop, charged at start: R2 R3 R10
        {6'b100000, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b000000, 12'd1400, 10'd250, 4'b0000, 4'd2},
        {6'b000000, 12'd1450, 10'd250, 4'b0000, 4'd3},
        {6'b000000, 12'd1440, 10'd250, 4'b0000, 4'd3},
        {6'b000000, 12'd1430, 10'd250, 4'b1010, 4'd3},
        {6'b000000, 12'd1000, 10'd250, 4'b0000, 4'd10},
        // NiMH hold-off then release: R4
        {6'b101000, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b001000, 12'd1200, 10'd250, 4'b0000, 4'd2},
        {6'b001000, 12'd1300, 10'd250, 4'b0000, 4'd4},
        {6'b001000, 12'd1280, 10'd250, 4'b0000, 4'd4},
        {6'b001001, 12'd1285, 10'd250, 4'b1010, 4'd4},
        // NiMH early slope limit 15: R5 R6
        {6'b101100, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b001100, 12'd1200, 10'd200, 4'b0000, 4'd6},
        {6'b001100, 12'd1200, 10'd205, 4'b0000, 4'd6},
        {6'b001100, 12'd1200, 10'd210, 4'b0000, 4'd6},
        {6'b001100, 12'd1200, 10'd215, 4'b0000, 4'd6},
        {6'b001100, 12'd1200, 10'd214, 4'b0000, 4'd5},
        {6'b001100, 12'd1200, 10'd221, 4'b1100, 4'd5},
        // NiMH late slope limit 10: R5 R9
        {6'b101101, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b001101, 12'd1400, 10'd300, 4'b0000, 4'd6},
        {6'b001101, 12'd1400, 10'd302, 4'b0000, 4'd6},
        {6'b001101, 12'd1400, 10'd304, 4'b0000, 4'd6},
        {6'b001101, 12'd1400, 10'd306, 4'b0000, 4'd6},
        {6'b001101, 12'd1400, 10'd309, 4'b0000, 4'd5},
        {6'b001101, 12'd1400, 10'd313, 4'b1101, 4'd9},
        // NiCd slope limit 20: R5
        {6'b100100, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b000100, 12'd1400, 10'd300, 4'b0000, 4'd6},
        {6'b000100, 12'd1400, 10'd305, 4'b0000, 4'd6},
        {6'b000100, 12'd1400, 10'd310, 4'b0000, 4'd6},
        {6'b000100, 12'd1400, 10'd315, 4'b0000, 4'd6},
        {6'b000100, 12'd1400, 10'd319, 4'b0000, 4'd5},
        {6'b000100, 12'd1400, 10'd325, 4'b1100, 4'd5},
        // thermistor absent: R7
        {6'b100000, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b000000, 12'd1400, 10'd300, 4'b0000, 4'd7},
        {6'b000000, 12'd1400, 10'd350, 4'b0000, 4'd7},
        {6'b000000, 12'd1400, 10'd400, 4'b0000, 4'd7},
        {6'b000000, 12'd1400, 10'd450, 4'b0000, 4'd7},
        {6'b000000, 12'd1400, 10'd500, 4'b0000, 4'd7},
        {6'b000000, 12'd1400, 10'd550, 4'b0000, 4'd7},
        {6'b000000, 12'd1380, 10'd600, 4'b1010, 4'd7},
        // start from recharge, NiMH voltage active at once: R4
        {6'b101010, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b001010, 12'd1200, 10'd250, 4'b0000, 4'd2},
        {6'b001010, 12'd1210, 10'd250, 4'b0000, 4'd4},
        {6'b001010, 12'd1200, 10'd250, 4'b1010, 4'd4},
        // recharge NiMH slope fixed at 10 in the early window: R5
        {6'b101110, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b001110, 12'd1200, 10'd100, 4'b0000, 4'd6},
        {6'b001110, 12'd1200, 10'd102, 4'b0000, 4'd6},
        {6'b001110, 12'd1200, 10'd104, 4'b0000, 4'd6},
        {6'b001110, 12'd1200, 10'd106, 4'b0000, 4'd6},
        {6'b001110, 12'd1200, 10'd110, 4'b1100, 4'd5},
        // pause: peak frozen, no fire: R8
        {6'b100000, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b000000, 12'd1400, 10'd250, 4'b0000, 4'd2},
        {6'b000000, 12'd1450, 10'd250, 4'b0000, 4'd8},
        {6'b010000, 12'd1500, 10'd250, 4'b0000, 4'd8},
        {6'b010000, 12'd1300, 10'd250, 4'b0000, 4'd8},
        {6'b000000, 12'd1440, 10'd250, 4'b0000, 4'd8},
        {6'b000000, 12'd1430, 10'd250, 4'b1010, 4'd8},
        // both criteria on one sample: R9
        {6'b100100, 12'd0,    10'd0,   4'b0000, 4'd11},
        {6'b000100, 12'd1400, 10'd300, 4'b0000, 4'd2},
        {6'b000100, 12'd1450, 10'd305, 4'b0000, 4'd3},
        {6'b000100, 12'd1440, 10'd310, 4'b0000, 4'd3},
        {6'b000100, 12'd1445, 10'd315, 4'b0000, 4'd3},
        {6'b000100, 12'd1430, 10'd320, 4'b1110, 4'd9}
    };

    task automatic check_out(input logic [3:0] exp, input int req);
        logic [3:0] act;
        act = {term_pulse, term_cause, slope_late};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: got pulse/cause/late=%b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic vld, input logic [11:0] mv,
                         input logic [9:0] t);
        fc_start  = st;
        smp_valid = vld;
        cell_mv   = mv;
        temp_dt   = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out(4'b0000, 1); // R1 outputs during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_out(4'b0000, 1); // R1 after reset

        // R1: sample before any start is ignored
        drive(1'b0, 1'b1, 12'd1000, 10'd0);
        @(negedge clk);
        check_out(4'b0000, 1);
        drive(1'b0, 1'b1, 12'd900, 10'd0);
        @(negedge clk);
        check_out(4'b0000, 1);

        // R11: sample coincident with start is discarded
        drive(1'b1, 1'b1, 12'd1500, 10'd0);
        @(negedge clk);
        check_out(4'b0000, 11);
        drive(1'b0, 1'b1, 12'd1400, 10'd0);
        @(negedge clk);
        check_out(4'b0000, 11);
        drive(1'b0, 1'b1, 12'd1380, 10'd0);
        @(negedge clk);
        check_out(4'b1010, 3);
        drive(1'b0, 1'b0, 12'd0, 10'd0);

        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            pause         = v[34];
            chem_nimh     = v[33];
            therm_en      = v[32];
            from_recharge = v[31];
            hold_win_done = v[30];
            drive(v[35], !v[35], v[29:18], v[17:8]);
            @(negedge clk);
            check_out(v[7:4], int'(v[3:0]));
            drive(1'b0, 1'b0, v[29:18], v[17:8]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule